// File: doc/BRIEF.md
# Bit-serial signed multiplier with parallel operand

This block multiplies a 16-bit two's-complement operand, held in a local register, by a second 16-bit two's-complement operand that arrives one bit per clock, least significant bit first. The 32-bit signed product leaves one bit per clock, also least significant bit first. A bit-serial datapath can therefore multiply at the same rate per bit as it adds.

The arithmetic core is a chain of identical cells, one per bit of the held operand. Each cell gates its operand bit with the current serial bit and feeds the result into a full adder with a registered sum and a registered carry. Sums move one cell toward the output each clock, and carries stay in their cell.

After the sixteenth serial bit the block repeats the captured sign bit internally for sixteen more clocks, so the whole product drains out. A small serial subtractor at the output removes the weight error of the held operand's sign bit. It uses the inverted partial product and an injected carry, fed from a delayed copy of the serial operand.

Top module: `sp_mul`

## Requirements
- R1: After reset `prod_vld` and `prod_bit` are 0.
- R2: When `load` is high, `busy` is low and `start` is low at a clock edge, `par_in` becomes the held operand. Its bit 15 is the sign bit.
- R3: A product starts at the clock edge where `start` is high and the block is idle. `ser_in` is taken at that edge as serial bit 0, and at each of the next 15 edges as bits 1 to 15. Bit 15 is the sign bit.
- R4: `prod_vld` is high for exactly 32 consecutive cycles, starting in the cycle after the start edge. In the k-th of these cycles (k = 0..31), `prod_bit` carries bit k of the 32-bit two's-complement product.
- R5: `ser_in` is ignored from the 17th edge of a product onward. The upper 16 serial bits are the captured sign.
- R6: The corner operands -32768 and 32767 give exact products, for example (-32768)·(-32768) = 0x40000000 and 32767·(-32768) = 0xC0008000.
- R7: `load` while a product is in progress does not change the held operand.
- R8: `start` while a product is in progress is ignored and does not restart the count.
- R9: `clr` zeroes all sum and carry bits and aborts a product. `prod_vld` and `prod_bit` are 0 in the next cycle, and a following product is exact.
- R10: Each product starts from an empty chain, so back-to-back products do not depend on earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of sum/carry state, aborts a product |
| load | input | 1 | Load `par_in` as the held operand |
| par_in | input | 16 | Parallel operand, two's complement |
| start | input | 1 | Begin a product; serial bit 0 is on `ser_in` |
| ser_in | input | 1 | Serial operand bit, LSB first |
| busy | output | 1 | Product in progress |
| prod_vld | output | 1 | `prod_bit` carries a product bit |
| prod_bit | output | 1 | Serial product bit, LSB first |

## Verification
The in-line properties check on every cycle that the column count advances by one per clock and stops after 32 columns. They also check that a start or a load during a product leaves the count and the held operand alone, that `prod_vld` only rises after a start, and that a clear silences the output in the next cycle. Whether the serial bits form the correct signed product only shows at the ports. The bench scenarios cover this: random operand pairs, the extreme values, a noisy serial input after the sign bit, and back-to-back products that begin with a non-empty chain.

// File: rtl/sp_mul_pkg.sv
package sp_mul_pkg;
  // full-adder sum and carry, shared by the cells and the output subtractor
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/sp_mul_cell.sv
module sp_mul_cell
  import sp_mul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic fresh,   // first column of a product: ignore stored state
  input  logic a_bit,
  input  logic b,
  input  logic up,      // sum from the next more significant cell
  output logic s_q
);
  logic c_q;
  logic pp, up_g, c_g;

  assign pp   = a_bit & b;
  assign up_g = fresh ? 1'b0 : up;
  assign c_g  = fresh ? 1'b0 : c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (clr) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (en) begin
      s_q <= fa_sum(pp, up_g, c_g);
      c_q <= fa_carry(pp, up_g, c_g);
    end
  end
endmodule

// File: rtl/sp_mul_chain.sv
module sp_mul_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         fresh,
  input  logic [W-1:0] a,
  input  logic         b,
  output logic         col0   // sum of the current output column (registered)
);
  logic [W:0] s_ext;
  assign s_ext[W] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    sp_mul_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (en),
      .fresh (fresh),
      .a_bit (a[i]),
      .b     (b),
      .up    (s_ext[i+1]),
      .s_q   (s_ext[i])
    );
  end

  assign col0 = s_ext[0];
endmodule

// File: rtl/sp_mul_seq.sv
module sp_mul_seq #(
  parameter int W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         start,
  output logic                         busy,
  output logic                         step,
  output logic                         fresh,
  output logic [$clog2(2*W)-1:0]       t_col
);
  localparam int N  = 2 * W;
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign step  = (busy | start) & ~clr;
  assign fresh = step & ~busy;
  assign t_col = busy ? cnt : '0;
  assign last  = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      busy <= !last;
      cnt  <= last ? '0 : cnt + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
    end
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !clr) |=> (busy && cnt == $past(cnt) + 1'b1));

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clr) |=> !busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last && !clr) |=> (cnt != CW'(1)));
endmodule

// File: rtl/sp_mul_fix.sv
module sp_mul_fix
  import sp_mul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   en,
  input  logic [$clog2(2*W)-1:0] t_col,
  input  logic                   ser_in,
  input  logic                   a_msb,
  input  logic                   col0,
  output logic                   out_bit
);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] WT = CW'(W);

  logic [W-1:0] dly;      // copy of the low serial bits, oldest at bit 0
  logic         hi_q;     // current output column is in the upper half
  logic         first_q;  // current output column is the first upper one
  logic         d_q;      // serial bit aligned with the current column
  logic         bor_q;    // carry of the correction adder
  logic         sub, cin;

  assign sub     = ~(a_msb & d_q);
  assign cin     = first_q ? 1'b1 : bor_q;
  assign out_bit = hi_q ? fa_sum(col0, sub, cin) : col0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0; hi_q <= 1'b0; first_q <= 1'b0; d_q <= 1'b0; bor_q <= 1'b0;
    end else if (clr) begin
      dly <= '0; hi_q <= 1'b0; first_q <= 1'b0; d_q <= 1'b0; bor_q <= 1'b0;
    end else begin
      bor_q <= hi_q ? fa_carry(col0, sub, cin) : 1'b0;
      if (en) begin
        hi_q    <= (t_col >= WT);
        first_q <= (t_col == WT);
        d_q     <= (t_col >= WT) ? dly[0] : 1'b0;
        dly     <= {(t_col < WT) ? ser_in : 1'b0, dly[W-1:1]};
      end
    end
  end
endmodule

// File: rtl/sp_mul.sv
module sp_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] par_in,
  input  logic         start,
  input  logic         ser_in,
  output logic         busy,
  output logic         prod_vld,
  output logic         prod_bit
);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] SIGN_COL = CW'(W - 1);
  localparam logic [CW-1:0] WT       = CW'(W);

  logic [W-1:0]  a_q;
  logic          sign_q;
  logic          step, fresh, b_eff, col0, fixed;
  logic [CW-1:0] t_col;

  sp_mul_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
    .busy(busy), .step(step), .fresh(fresh), .t_col(t_col)
  );

  assign b_eff = (t_col < WT) ? ser_in : sign_q;

  sp_mul_chain #(.W(W)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(step), .fresh(fresh),
    .a(a_q), .b(b_eff), .col0(col0)
  );

  sp_mul_fix #(.W(W)) u_fix (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(step), .t_col(t_col),
    .ser_in(ser_in), .a_msb(a_q[W-1]), .col0(col0), .out_bit(fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      sign_q <= 1'b0;
    end else begin
      if (load && !busy && !start) a_q <= par_in;
      if (step && t_col == SIGN_COL) sign_q <= ser_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prod_vld <= 1'b0;
    else if (clr) prod_vld <= 1'b0;
    else          prod_vld <= step;
  end

  assign prod_bit = prod_vld & fixed;

  p_operand_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> $stable(a_q));

  p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!prod_vld && !prod_bit));

  p_vld_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prod_vld) |-> $past(start));
endmodule

// File: tb/sp_mul_tb.sv
module sp_mul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, load = 1'b0, start = 1'b0, ser_in = 1'b0;
  logic [15:0] par_in = '0;
  logic        busy, prod_vld, prod_bit;
  int          n_chk = 0, n_fail = 0;

  always #10ns clk = ~clk;

  sp_mul u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .par_in(par_in),
    .start(start), .ser_in(ser_in), .busy(busy), .prod_vld(prod_vld),
    .prod_bit(prod_bit)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b);
    longint pa = longint'($signed(a));
    longint pb = longint'($signed(b));
    longint pr = pa * pb;
    return pr[31:0];
  endfunction

  // mode: 0 normal, 1 noisy tail, 2 load during product, 3 start during product
  task automatic do_product(input logic [15:0] a, input logic [15:0] b,
                            input int mode, input string req);
    logic [31:0] got = '0;
    bit          vld_all = 1'b1;
    @(negedge clk); load = 1'b1; par_in = a;
    @(negedge clk); load = 1'b0; par_in = ~a; start = 1'b1; ser_in = b[0];
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      got[k] = prod_bit;
      if (!prod_vld) vld_all = 1'b0;
      start = 1'b0;
      load  = 1'b0;
      if (k == 3 && mode == 2) begin load = 1'b1; par_in = 16'h1234; end
      if (k == 3 && mode == 3) start = 1'b1;
      if (k + 1 < 16)      ser_in = b[k+1];
      else if (mode == 1)  ser_in = $urandom_range(0, 1) != 0;
      else                 ser_in = b[15];
    end
    chk(vld_all, {req, " R4 valid for 32 cycles"}, 0, 1);
    chk(got == ref_prod(a, b), {req, " R2 R3 R4 product"}, got, ref_prod(a, b));
    @(negedge clk);
    chk(!prod_vld, {req, " R4 valid ends"}, prod_vld, 0);
  endtask

  task automatic t_reset();
    chk(!prod_vld && !prod_bit, "R1 reset outputs", {prod_vld, prod_bit}, 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++)
      do_product(16'($urandom), 16'($urandom), 0, "R10 random back-to-back");
    do_product(16'h0003, 16'h0005, 0, "R4 small");
    do_product(16'hFFFF, 16'hFFFF, 0, "R4 minus one squared");
  endtask

  task automatic t_corners();
    do_product(16'h8000, 16'h8000, 0, "R6 min*min");
    do_product(16'h7FFF, 16'h8000, 0, "R6 max*min");
    do_product(16'h8000, 16'h7FFF, 0, "R6 min*max");
    do_product(16'h7FFF, 16'h7FFF, 0, "R6 max*max");
    do_product(16'h8000, 16'h0000, 0, "R6 min*zero");
  endtask

  task automatic t_tail();
    do_product(16'h8001, 16'hC35A, 1, "R5 noisy tail neg");
    do_product(16'h5A5A, 16'h1234, 1, "R5 noisy tail pos");
  endtask

  task automatic t_load_busy();
    do_product(16'hF00D, 16'h0BAD, 2, "R7 load while busy");
  endtask

  task automatic t_start_busy();
    do_product(16'h2345, 16'hE001, 3, "R8 start while busy");
  endtask

  task automatic t_clear();
    @(negedge clk); load = 1'b1; par_in = 16'h7FFF;
    @(negedge clk); load = 1'b0; start = 1'b1; ser_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); start = 1'b0; ser_in = 1'b1;
    end
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(!prod_vld && !prod_bit, "R9 clear silences output", {prod_vld, prod_bit}, 0);
    chk(!busy, "R9 clear aborts", busy, 0);
    do_product(16'h8000, 16'hFFFF, 0, "R9 product after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_corners();
    t_tail();
    t_load_busy();
    t_start_busy();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule